// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It has a table of saturating counters. Each row of the table is chosen by a slice of the branch address. A global shift register records the real outcomes of the most recent resolved branches, and its value chooses one counter inside that row. The fetch side presents a PC and gets a taken or not-taken guess back in the same cycle, with no clock edge in between. When a branch resolves, the execute side presents its PC and real direction on the update port. On the next clock edge the chosen counter is trained and the outcome is shifted into the history.

Rows carry no tag. Branches whose addresses agree in the row-select bits share a row. The history length, the counter width, the row count and the position of the row-select slice are all parameters. The defaults are two history bits, two-bit counters and sixteen rows, which gives 128 bits of counter storage.

Top module: `corr_predictor`

## Requirements
- R1: `lk_taken` is the most significant bit of the counter at row `lk_pc[ROW_LSB +: log2(ROWS)]` and set `hist`. It follows `lk_pc` with no clock edge in between.
- R2: The history register holds the last HIST_BITS real outcomes, with the newest in bit 0 and 1 meaning taken. It changes only on a clock edge where `up_valid` is high. Idle cycles leave every prediction unchanged.
- R3: The selected counter has 2^CTR_BITS states. An update with `up_taken`=1 moves it up by one, and an update with `up_taken`=0 moves it down by one. It saturates at zero and at the all-ones value.
- R4: The counter written by an update is the one indexed by the history as it was before that update's shift. A lookup made in the same cycle as an update returns the state from before the update.
- R5: A synchronous active-high `rst` sets every counter to zero (strongly not taken) and clears the history to zero. After reset every lookup predicts not taken.
- R6: PCs that agree in the row-select bits use the same row. All other PC bits have no effect on the prediction.
- R7: Every (row, history) pair has its own counter, giving ROWS×2^HIST_BITS×CTR_BITS bits of storage (128 bits at the defaults). Training one pair leaves every other pair unchanged.
- R8: With CTR_BITS=2, a counter saturated at taken still predicts taken after one not-taken update.
- R9: With HIST_BITS=1, a branch pair that alternates between both-taken and both-not-taken becomes fully predictable after warm-up. In this pattern the second branch is not taken whenever the first is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_BITS | Address of the branch being fetched |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_BITS | Address of the resolved branch |
| up_taken | input | 1 | Real direction of the resolved branch |

## Verification
The assertions assume that `up_pc` and `up_taken` are known whenever `up_valid` is high. They also assume that a lookup PC held steady across an idle cycle is a true repeat of the same query. The bench raises `up_valid` for one clock at a time and sets the address and outcome in the same step. It changes `lk_pc` only at falling edges, so the combinational output has settled before it is sampled. The bench keeps its own model of the counters and history, which it updates only at the clock edges where an update is applied.

// File: rtl/corr_predictor.sv
module corr_predictor #(
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  parameter int ROWS      = 16,
  parameter int PC_BITS   = 32,
  parameter int ROW_LSB   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PC_BITS-1:0] lk_pc,
  output logic               lk_taken,
  input  logic               up_valid,
  input  logic [PC_BITS-1:0] up_pc,
  input  logic               up_taken
);
  localparam int ROW_W      = $clog2(ROWS);
  localparam int SETS       = 1 << HIST_BITS;
  localparam int ENTRIES    = ROWS * SETS;
  localparam int IDX_W      = ROW_W + HIST_BITS;
  localparam int STORE_BITS = ENTRIES * CTR_BITS;
  localparam logic [CTR_BITS-1:0] CTR_TOP = '1;

  logic [CTR_BITS-1:0]  ctr [ENTRIES];
  logic [HIST_BITS-1:0] hist;
  logic [HIST_BITS:0]   hist_ext;
  logic [IDX_W-1:0]     rd_idx, wr_idx;
  logic [CTR_BITS-1:0]  wr_old, wr_new;
  logic                 unused_pc;
  logic                 armed;

  assign unused_pc = ^{lk_pc, up_pc, STORE_BITS[0]};
  assign rd_idx    = {lk_pc[ROW_LSB +: ROW_W], hist};
  assign wr_idx    = {up_pc[ROW_LSB +: ROW_W], hist};
  assign lk_taken  = ctr[rd_idx][CTR_BITS-1];
  assign wr_old    = ctr[wr_idx];
  assign hist_ext  = {hist, up_taken};

  always_comb begin
    if (up_taken) wr_new = (wr_old == CTR_TOP) ? wr_old : wr_old + 1'b1;
    else          wr_new = (wr_old == '0)      ? wr_old : wr_old - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ctr[i] <= '0;
      hist <= '0;
    end else if (up_valid) begin
      ctr[wr_idx] <= wr_new;
      hist        <= hist_ext[HIST_BITS-1:0];
    end
  end

  always_ff @(posedge clk) armed <= rst | armed;

  assert_reset_clears_R5: assert property (@(posedge clk)
    rst |=> (hist == '0 && !lk_taken));

  assert_hist_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && !up_valid) |=> $stable(hist));

  assert_lookup_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(up_valid) && !$past(rst) && $stable(lk_pc)) |-> $stable(lk_taken));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && up_valid && up_taken && wr_old == CTR_TOP) |=> ctr[$past(wr_idx)] == CTR_TOP);

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && up_valid && !up_taken && wr_old == '0) |=> ctr[$past(wr_idx)] == '0);

  assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && up_valid && !up_taken && wr_old != '0) |=> ctr[$past(wr_idx)] == $past(wr_old) - 1'b1);
endmodule

// File: tb/sim_corr_predictor.sv
`timescale 1ns/1ps
module sim_corr_predictor;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst;
  logic [31:0] a_lk_pc, a_up_pc, b_lk_pc, b_up_pc;
  logic a_lk_taken, a_up_valid, a_up_taken;
  logic b_lk_taken, b_up_valid, b_up_taken;

  corr_predictor u0 (.clk(clk), .rst(rst), .lk_pc(a_lk_pc), .lk_taken(a_lk_taken),
    .up_valid(a_up_valid), .up_pc(a_up_pc), .up_taken(a_up_taken));

  corr_predictor #(.HIST_BITS(1)) u1 (.clk(clk), .rst(rst), .lk_pc(b_lk_pc), .lk_taken(b_lk_taken),
    .up_valid(b_up_valid), .up_pc(b_up_pc), .up_taken(b_up_taken));

  int checks = 0, fails = 0;
  int m_ctr [64];
  int m_hist;

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic int m_idx(input logic [31:0] pc);
    return (int'(pc[5:2]) << 2) | m_hist;
  endfunction

  function automatic logic m_pred(input logic [31:0] pc);
    return m_ctr[m_idx(pc)] >= 2;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 64; i++) m_ctr[i] = 0;
    m_hist = 0;
  endtask

  task automatic a_update(input logic [31:0] pc, input logic t);
    int k;
    @(negedge clk); a_up_valid = 1; a_up_pc = pc; a_up_taken = t;
    @(posedge clk);
    k = m_idx(pc);
    if (t && m_ctr[k] < 3) m_ctr[k]++;
    if (!t && m_ctr[k] > 0) m_ctr[k]--;
    m_hist = ((m_hist << 1) | int'(t)) & 3;
    #1 a_up_valid = 0;
  endtask

  task automatic a_look(input logic [31:0] pc, input string req);
    @(negedge clk); a_lk_pc = pc; #1;
    check(a_lk_taken, m_pred(pc), req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    m_reset();
  endtask

  initial begin
    #1ms;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 0; a_lk_pc = 0; a_up_pc = 0; a_up_valid = 0; a_up_taken = 0;
    b_lk_pc = 0; b_up_pc = 0; b_up_valid = 0; b_up_taken = 0;
    m_reset();
    do_reset();

    // R5: all rows predict not taken after reset
    for (int r = 0; r < 16; r++) a_look(r << 2, "R5 reset row");

    // R8: saturate counter at row 3 history 11, one not-taken, restore history
    for (int i = 0; i < 5; i++) a_update(32'h0C, 1);
    a_update(32'h0C, 0);
    a_update(32'h20, 1);
    a_update(32'h20, 1);
    @(negedge clk); a_lk_pc = 32'h0C; #1;
    check(a_lk_taken, 1'b1, "R8 loop exit keeps taken");

    // R4: same-cycle lookup sees old state; write uses pre-shift history
    @(negedge clk); a_up_valid = 1; a_up_pc = 32'h0C; a_up_taken = 0; a_lk_pc = 32'h0C; #1;
    check(a_lk_taken, 1'b1, "R4 same-cycle old state");
    @(posedge clk); m_ctr[(3 << 2) | 3]--; m_hist = 2; #1 a_up_valid = 0;
    a_update(32'h20, 1); a_update(32'h20, 1);
    a_look(32'h0C, "R4 pre-shift index");
    @(negedge clk); a_lk_pc = 32'h0C; #1;
    check(a_lk_taken, 1'b0, "R4 counter at 11 trained down");

    // R6: upper PC bits and low alignment bits ignored
    for (int r = 0; r < 16; r++) begin
      logic [31:0] p = (r << 2);
      a_look(p, "R6 base");
      @(negedge clk); a_lk_pc = p | 32'hFFFF_FFC3; #1;
      check(a_lk_taken, m_pred(p), "R6 alias");
    end

    // R1 R2 R3 R7: pseudo-random training against model, idle gaps included
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] p = $urandom;
      logic t = (($urandom % 4) == 0) ^ p[2] ^ m_hist[0];
      a_update(p, t);
      if (n % 7 == 0) repeat (2) @(negedge clk);
      a_look($urandom, "R1 R3 R7 sweep");
      if (n % 500 == 0)
        for (int r = 0; r < 16; r++) a_look(r << 2, "R2 R7 full row sweep");
    end

    // R5: reset after training
    do_reset();
    for (int r = 0; r < 16; r++) a_look((r << 2) | 32'h100, "R5 reset after training");

    // R9: one-bit history correlation on u1
    for (int it = 0; it < 10; it++) begin
      logic t = (it % 2 == 0);
      for (int b = 0; b < 2; b++) begin
        @(negedge clk); b_lk_pc = 32'h40 + b * 4; #1;
        if (it >= 4) check(b_lk_taken, t, "R9 correlated pair");
        b_up_valid = 1; b_up_pc = b_lk_pc; b_up_taken = t;
        @(posedge clk); #1 b_up_valid = 0;
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule